// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is a single periodic timer channel. While enabled it counts a 32-bit value down by one on every selected tick strobe. The strobe comes either from a bus-clock tick input or from an external 1 MHz tick input, as chosen by a select input. When the count is zero, the next tick loads the reload value, so the channel repeats with a period of reload+1 ticks. With a reload of zero the count stays at zero.

Two match registers are compared against each value the count reaches through a tick. The zero value is also compared. Each qualifying event inverts a level-type interrupt output. The two match registers can be written in either order of magnitude. Because the count falls, the larger match value always fires first in a pass. The host can write the live count, the reload value and both match values through dedicated write strobes. The live count is visible on an output for readback.

Top module: `dmt_channel`

## Requirements
- R1: Reset sets the count, the reload value, both match values and the interrupt level to zero. After reset, the first tick that takes the count from 1 to 0 toggles the interrupt even with overflow interrupts off, because the match values are zero.
- R2: With `use_ext_tick`=1 only `ext_tick` advances the count. With `use_ext_tick`=0 only `bus_tick` advances it. A strobe on the unselected input changes nothing.
- R3: On a selected tick while enabled, a nonzero count decreases by one. A zero count loads the reload value.
- R4: When a tick moves the count to a value equal to either match register, the interrupt toggles exactly once, even when both match registers hold that value. With unequal match values, the larger one fires first in each pass.
- R5: When a tick moves the count to zero, the interrupt toggles if `ovf_irq_en`=1 or if either match register is zero. Otherwise that step produces no toggle.
- R6: Every event inverts `irq_lvl`. The level holds between events and is never a one-cycle pulse.
- R7: With a reload value of zero and a count of zero, ticks leave the count at zero and produce no events.
- R8: A count write while `chan_en`=1 sets the count to the written value on the next edge. It wins over a tick in the same cycle, and it produces no event. A count write while `chan_en`=0 is ignored.
- R9: A reload write while enabled, when the stored reload is zero and the written value is nonzero, loads the new value into the count. Any other reload write only updates the stored value, which is used at the next wrap.
- R10: The first enabled cycle after a disabled one loads the stored reload value into the count. That stored value is the one held before any reload write in the same cycle. A tick in that cycle is ignored. While disabled, the count holds and no events occur.
- R11: A match write is compared from the following cycle on. A tick in the same cycle as the write is compared against the old match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| use_ext_tick | input | 1 | 1 selects the external tick, 0 selects the bus-clock tick |
| ovf_irq_en | input | 1 | Qualifies the event on reaching zero |
| bus_tick | input | 1 | Tick strobe from the bus clock |
| ext_tick | input | 1 | External 1 MHz tick strobe |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write value |
| rld_wr | input | 1 | Reload write strobe |
| rld_wdata | input | 32 | Reload write value |
| mat_a_wr | input | 1 | First match write strobe |
| mat_a_wdata | input | 32 | First match write value |
| mat_b_wr | input | 1 | Second match write strobe |
| mat_b_wdata | input | 32 | Second match write value |
| cnt_q | output | 32 | Live count |
| irq_lvl | output | 1 | Toggling interrupt level |

## Verification
The hardest situations to reach from the ports are collisions within a single cycle. Examples are a count write meeting a tick, an enable edge meeting a tick and a reload write, and a match write landing on the very tick that reaches the written value. With 32-bit values, random data would almost never make the count meet a match value. The random phase therefore keeps reload, match and count values below 24 and toggles enable rarely, so that wraps, match hits and zero events recur often. Directed sequences then force each collision once: the same-cycle count write with a tick, the idle zero-reload state, the reload restart from zero, and a stale match compared on the write cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_WRITE,
    OP_ENLOAD,
    OP_RESTART,
    OP_TICK
  } cnt_op_e;
endpackage

// File: rtl/tick_mux.sv
module tick_mux (
  input  logic use_ext,
  input  logic bus_tick,
  input  logic ext_tick,
  output logic tick
);
  always_comb begin
    tick = use_ext ? ext_tick : bus_tick;
  end
endmodule

// File: rtl/down_counter.sv
module down_counter
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_wr,
  input  logic [W-1:0] rld_wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         en_q,
  output logic         step_vld,
  output logic [W-1:0] step_val
);
  cnt_op_e      op;
  logic [W-1:0] cnt_d;
  logic [W-1:0] tick_val;

  // value reached by a tick: wrap to reload at zero
  always_comb begin
    tick_val = (cnt_q == '0) ? rld_q : (cnt_q - W'(1));
  end

  // priority: count write, enable edge, reload restart, tick
  always_comb begin
    op = OP_HOLD;
    if (chan_en) begin
      if (cnt_wr)                                             op = OP_WRITE;
      else if (!en_q)                                         op = OP_ENLOAD;
      else if (rld_wr && (rld_q == '0) && (rld_wdata != '0))  op = OP_RESTART;
      else if (tick)                                          op = OP_TICK;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    unique case (op)
      OP_WRITE:   cnt_d = cnt_wdata;
      OP_ENLOAD:  cnt_d = rld_q;
      OP_RESTART: cnt_d = rld_wdata;
      OP_TICK:    cnt_d = tick_val;
      default:    cnt_d = cnt_q;
    endcase
    step_vld = (op == OP_TICK) && (tick_val != cnt_q);
    step_val = tick_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= chan_en;
      if (op != OP_HOLD) cnt_q <= cnt_d;
      if (rld_wr)        rld_q <= rld_wdata;
    end
  end
endmodule

// File: rtl/match_event.sv
module match_event #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mat_a_wr,
  input  logic [W-1:0] mat_a_wdata,
  input  logic         mat_b_wr,
  input  logic [W-1:0] mat_b_wdata,
  input  logic         ovf_irq_en,
  input  logic         step_vld,
  input  logic [W-1:0] step_val,
  output logic         irq_lvl
);
  localparam int NMAT = 2;

  logic [W-1:0]    mat_q  [NMAT];
  logic [NMAT-1:0] mat_wr;
  logic [W-1:0]    mat_wd [NMAT];
  logic [NMAT-1:0] mat_hit;
  logic            zero_hit;
  logic            evt;

  always_comb begin
    mat_wr    = {mat_b_wr, mat_a_wr};
    mat_wd[0] = mat_a_wdata;
    mat_wd[1] = mat_b_wdata;
  end

  for (genvar g = 0; g < NMAT; g++) begin : g_mat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mat_q[g] <= '0;
      else if (mat_wr[g]) mat_q[g] <= mat_wd[g];
    end
    always_comb mat_hit[g] = (step_val == mat_q[g]);
  end

  always_comb begin
    zero_hit = (step_val == '0) && ovf_irq_en;
    evt      = step_vld && ((|mat_hit) || zero_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_lvl <= 1'b0;
    else if (evt) irq_lvl <= ~irq_lvl;
  end
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic         use_ext_tick,
  input  logic         ovf_irq_en,
  input  logic         bus_tick,
  input  logic         ext_tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_wr,
  input  logic [W-1:0] rld_wdata,
  input  logic         mat_a_wr,
  input  logic [W-1:0] mat_a_wdata,
  input  logic         mat_b_wr,
  input  logic [W-1:0] mat_b_wdata,
  output logic [W-1:0] cnt_q,
  output logic         irq_lvl
);
  logic         tick;
  logic [W-1:0] rld_q;
  logic         en_q;
  logic         step_vld;
  logic [W-1:0] step_val;

  tick_mux u_tick (
    .use_ext  (use_ext_tick),
    .bus_tick (bus_tick),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  down_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .rld_wr    (rld_wr),
    .rld_wdata (rld_wdata),
    .cnt_q     (cnt_q),
    .rld_q     (rld_q),
    .en_q      (en_q),
    .step_vld  (step_vld),
    .step_val  (step_val)
  );

  match_event #(.W(W)) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .mat_a_wr    (mat_a_wr),
    .mat_a_wdata (mat_a_wdata),
    .mat_b_wr    (mat_b_wr),
    .mat_b_wdata (mat_b_wdata),
    .ovf_irq_en  (ovf_irq_en),
    .step_vld    (step_vld),
    .step_val    (step_val),
    .irq_lvl     (irq_lvl)
  );
endmodule

// File: rtl/dmt_channel_chk.sv
module dmt_channel_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         chan_en,
  input logic         bus_tick,
  input logic         ext_tick,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_wdata,
  input logic         rld_wr,
  input logic [W-1:0] rld_q,
  input logic         en_q,
  input logic [W-1:0] cnt_q,
  input logic         irq_lvl
);
  // R8: enabled count write lands on the next edge
  assert_cnt_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && cnt_wr) |=> (cnt_q == $past(cnt_wdata)));

  // R10: disabled channel holds its count
  assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> $stable(cnt_q));

  // R10: disabled channel produces no event
  assert_no_evt_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> $stable(irq_lvl));

  // R10: enable edge loads the stored reload value
  assert_en_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !en_q && !cnt_wr) |=> (cnt_q == $past(rld_q)));

  // R6: level changes only after a tick strobe
  assert_toggle_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_tick || ext_tick) |=> $stable(irq_lvl));

  // R7: zero reload parks the count at zero with no events
  assert_zero_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && chan_en && !cnt_wr && !rld_wr && rld_q == '0 && cnt_q == '0)
      |=> (cnt_q == '0 && $stable(irq_lvl)));
endmodule

bind dmt_channel dmt_channel_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .bus_tick  (bus_tick),
  .ext_tick  (ext_tick),
  .cnt_wr    (cnt_wr),
  .cnt_wdata (cnt_wdata),
  .rld_wr    (rld_wr),
  .rld_q     (rld_q),
  .en_q      (en_q),
  .cnt_q     (cnt_q),
  .irq_lvl   (irq_lvl)
);

// File: tb/test_dmt_channel.sv
module test_dmt_channel;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic         clk;
  logic         rst_n;
  logic         chan_en, use_ext_tick, ovf_irq_en, bus_tick, ext_tick;
  logic         cnt_wr, rld_wr, mat_a_wr, mat_b_wr;
  logic [W-1:0] cnt_wdata, rld_wdata, mat_a_wdata, mat_b_wdata;
  logic [W-1:0] cnt_q;
  logic         irq_lvl;

  int n_chk  = 0;
  int n_fail = 0;

  // reference state
  logic [W-1:0] m_cnt, m_rld, m_ma, m_mb;
  logic         m_irq, m_enq;

  dmt_channel #(.W(W)) i_dmt_channel (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .use_ext_tick(use_ext_tick),
    .ovf_irq_en(ovf_irq_en), .bus_tick(bus_tick), .ext_tick(ext_tick),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .rld_wr(rld_wr), .rld_wdata(rld_wdata),
    .mat_a_wr(mat_a_wr), .mat_a_wdata(mat_a_wdata), .mat_b_wr(mat_b_wr),
    .mat_b_wdata(mat_b_wdata), .cnt_q(cnt_q), .irq_lvl(irq_lvl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected next state from the requirements
  task automatic model_step();
    logic         tk;
    logic         stp;
    logic [W-1:0] nv;
    tk  = use_ext_tick ? ext_tick : bus_tick;          // R2
    stp = 1'b0;
    nv  = '0;
    if (chan_en) begin
      if (cnt_wr) m_cnt = cnt_wdata;                   // R8
      else if (!m_enq) m_cnt = m_rld;                  // R10
      else if (rld_wr && m_rld == 0 && rld_wdata != 0) m_cnt = rld_wdata; // R9
      else if (tk) begin                               // R3, R7
        nv = (m_cnt == 0) ? m_rld : m_cnt - 1;
        if (nv != m_cnt) begin stp = 1'b1; m_cnt = nv; end
      end
    end
    // R4, R5, R11: old match values
    if (stp && (nv == m_ma || nv == m_mb || (nv == 0 && ovf_irq_en))) m_irq = ~m_irq;
    if (rld_wr)   m_rld = rld_wdata;
    if (mat_a_wr) m_ma  = mat_a_wdata;
    if (mat_b_wr) m_mb  = mat_b_wdata;
    m_enq = chan_en;
  endtask

  // one cycle: inputs already set after a falling edge
  task automatic cyc(input string tag);
    model_step();
    @(negedge clk);
    chk({tag, " count"}, cnt_q, m_cnt);
    chk({tag, " irq"}, W'(irq_lvl), W'(m_irq));
    bus_tick = 0; ext_tick = 0; cnt_wr = 0; rld_wr = 0; mat_a_wr = 0; mat_b_wr = 0;
  endtask

  task automatic run_ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      bus_tick = 1;
      cyc(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; chan_en = 0; use_ext_tick = 0; ovf_irq_en = 0;
    bus_tick = 0; ext_tick = 0; cnt_wr = 0; rld_wr = 0; mat_a_wr = 0; mat_b_wr = 0;
    cnt_wdata = 0; rld_wdata = 0; mat_a_wdata = 0; mat_b_wdata = 0;
    m_cnt = 0; m_rld = 0; m_ma = 0; m_mb = 0; m_irq = 0; m_enq = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset count", cnt_q, 0);
    chk("R1 reset irq", W'(irq_lvl), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: zero reload and zero match values after reset
    chan_en = 1; cyc("R1 enable");
    chk("R1 count after enable", cnt_q, 0);
    cnt_wr = 1; cnt_wdata = 1; cyc("R1 load");
    run_ticks("R1 zero match", 1);
    chk("R1 irq from zero match", W'(irq_lvl), 1);

    // R4: unordered matches, larger first
    chan_en = 0; cyc("R10 disable");
    mat_a_wr = 1; mat_a_wdata = 3; mat_b_wr = 1; mat_b_wdata = 7;
    rld_wr = 1; rld_wdata = 10; cyc("R4 setup");
    chan_en = 1; bus_tick = 1; cyc("R10 enable with tick");
    chk("R10 enable loads reload", cnt_q, 10);
    run_ticks("R4", 3);
    chk("R4 larger match first", W'(irq_lvl), 0);
    run_ticks("R4 R6", 4);
    chk("R4 smaller match second", W'(irq_lvl), 1);
    run_ticks("R5 no ovf", 3);
    chk("R5 zero without ovf", W'(irq_lvl), 1);
    run_ticks("R3 wrap", 1);
    chk("R3 wrap to reload", cnt_q, 10);

    // R5: overflow qualified zero
    ovf_irq_en = 1;
    run_ticks("R5 ovf", 10);
    chk("R5 zero with ovf", cnt_q, 0);

    // R4: equal matches toggle once
    mat_b_wr = 1; mat_b_wdata = 3; cyc("R4 equal setup");
    cnt_wr = 1; cnt_wdata = 4; cyc("R8 load");
    run_ticks("R4 equal", 1);

    // R2: clock select
    use_ext_tick = 1; bus_tick = 1; cyc("R2 bus ignored");
    ext_tick = 1; cyc("R2 ext counts");
    use_ext_tick = 0; ext_tick = 1; cyc("R2 ext ignored");

    // R8: write beats tick; ignored while disabled
    cnt_wr = 1; cnt_wdata = 20; bus_tick = 1; cyc("R8 write vs tick");
    chk("R8 write wins", cnt_q, 20);
    chan_en = 0; cyc("R10 off");
    cnt_wr = 1; cnt_wdata = 5; cyc("R8 disabled write");
    chk("R8 disabled write ignored", cnt_q, 20);
    run_ticks("R10 disabled ticks", 3);

    // R7: zero reload parks
    rld_wr = 1; rld_wdata = 0; cyc("R7 setup");
    chan_en = 1; cyc("R7 enable");
    chk("R7 count zero", cnt_q, 0);
    run_ticks("R7 parked", 4);

    // R9: restart from zero reload
    rld_wr = 1; rld_wdata = 6; cyc("R9 restart");
    chk("R9 count from new reload", cnt_q, 6);
    rld_wr = 1; rld_wdata = 12; cyc("R9 stored only");
    chk("R9 no reload jump", cnt_q, 6);

    // R11: match written on the arriving tick uses the old value
    mat_a_wr = 1; mat_a_wdata = 5; mat_b_wr = 1; mat_b_wdata = 30;
    cyc("R11 setup");
    mat_a_wr = 1; mat_a_wdata = 4; bus_tick = 1; cyc("R11 same cycle");
    run_ticks("R11 next", 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      automatic int r = $urandom_range(0, 99);
      if (r < 3) chan_en = ~chan_en;
      use_ext_tick = ($urandom_range(0, 49) == 0) ? ~use_ext_tick : use_ext_tick;
      ovf_irq_en   = ($urandom_range(0, 29) == 0) ? ~ovf_irq_en : ovf_irq_en;
      bus_tick  = $urandom_range(0, 2) != 0;
      ext_tick  = $urandom_range(0, 2) != 0;
      cnt_wr    = $urandom_range(0, 39) == 0; cnt_wdata   = $urandom_range(0, 23);
      rld_wr    = $urandom_range(0, 29) == 0; rld_wdata   = $urandom_range(0, 23);
      mat_a_wr  = $urandom_range(0, 29) == 0; mat_a_wdata = $urandom_range(0, 23);
      mat_b_wr  = $urandom_range(0, 29) == 0; mat_b_wdata = $urandom_range(0, 23);
      cyc("random R3 R4 R5 R8 R9 R10 R11");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule